// File: doc/BRIEF.md
# Eight-LED Pattern Sequencer

This block steps a row of eight LEDs through a fixed light show and then loops. One pass has 32 steps in six phases. A single lit LED runs left, then a single lit LED runs right. A curtain opens from the middle outwards and then closes from the edges inwards. Neighbouring LEDs flash against each other, and finally the upper half flashes against the lower half.

Step timing comes from a divider on the system clock. `TICKS_PER_SEC` sets how many clocks make one second. The `slow_i` switch selects a step interval of one second (0) or two seconds (1). The switch is sampled only when a step ends, so every step runs for its full interval. The LED vector is active high, and bit 0 is the rightmost LED.

Top module: `led_pattern_seq`

## Requirements
- R1: While `rst_ni` is low, `led_o` is 00000001, the first step of the pass. The first step after reset lasts exactly `TICKS_PER_SEC` clocks.
- R2: Steps 0 to 7 light only bit k at step k (left-running light).
- R3: Steps 8 to 15 light only bit 15-k at step k (right-running light). Step 8 shows 10000000.
- R4: Steps 16 to 19 open a curtain from the centre outwards: 00011000, 00111100, 01111110, 11111111.
- R5: Steps 20 to 23 close the curtain from the edges inwards: 01111110, 00111100, 00011000, 00000000.
- R6: Steps 24 to 27 alternate 10101010, 01010101, 10101010, 01010101.
- R7: Steps 28 to 31 alternate 11110000, 00001111, 11110000, 00001111.
- R8: Step 0 follows step 31, and the pass repeats without a gap.
- R9: A step lasts `TICKS_PER_SEC` clocks when the sampled switch is 0 and `2*TICKS_PER_SEC` clocks when it is 1. `led_o` is stable within a step.
- R10: `slow_i` is sampled on the clock edge that ends a step and governs only the step that follows. After reset the sampled value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_i | input | 1 | Step interval select: 0 = 1 s, 1 = 2 s |
| led_o | output | 8 | LED drive, active high |

## Verification
The bench goes after the 7-to-8 seam, where both steps show 10000000. A design that merged the two running lights or skipped one position would shift every later step by one. Speed toggles land mid-step, so a design that applied `slow_i` at once would cut short or stretch the current step. The first step is held at one second while `slow_i` is high in reset, which catches a timer that loads the switch at reset. A reset is also applied in the middle of a step, which catches a divider that keeps its partial count and so shortens the first step after reset.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

  typedef enum logic [2:0] {
    PH_LEFT,
    PH_RIGHT,
    PH_OPEN,
    PH_CLOSE,
    PH_ALT,
    PH_HALVES
  } phase_e;

  localparam int unsigned FLASH_STEPS = 4;

  // lit state of LED bit i at offset off inside phase ph, row width w
  function automatic logic led_bit_on(phase_e ph, int unsigned off,
                                      int unsigned i, int unsigned w);
    int unsigned half;
    half = w / 2;
    case (ph)
      PH_LEFT:   return off == i;
      PH_RIGHT:  return off == (w - 1 - i);
      PH_OPEN:   return (i + off >= half - 1) && (i <= half + off);
      PH_CLOSE:  return (i > off) && (i + off < w - 1);
      PH_ALT:    return (off % 2 == 1) ? (i % 2 == 0) : (i % 2 == 1);
      PH_HALVES: return (off % 2 == 1) ? (i < half) : (i >= half);
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/led_step_timer.sv
module led_step_timer #(
  parameter int unsigned TICKS = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  localparam int unsigned SLOW_TICKS = 2 * TICKS;
  localparam int unsigned CNT_W      = $clog2(SLOW_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             slow_q;

  assign limit  = slow_q ? CNT_W'(SLOW_TICKS - 1) : CNT_W'(TICKS - 1);
  assign tick_o = (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q  <= '0;
      slow_q <= slow_i;  // speed of the next step only
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/led_step_counter.sv
module led_step_counter #(
  parameter int unsigned N_STEPS = 32,
  localparam int unsigned IDX_W  = $clog2(N_STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      idx_o <= '0;
    else if (tick_i)
      idx_o <= (idx_o == IDX_W'(N_STEPS - 1)) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/led_pattern_map.sv
module led_pattern_map
  import led_seq_pkg::*;
#(
  parameter int unsigned LED_W   = 8,
  parameter int unsigned N_STEPS = 32,
  localparam int unsigned IDX_W  = $clog2(N_STEPS)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [LED_W-1:0] led_o
);
  localparam int unsigned HALF     = LED_W / 2;
  localparam int unsigned B_RIGHT  = LED_W;
  localparam int unsigned B_OPEN   = 2 * LED_W;
  localparam int unsigned B_CLOSE  = B_OPEN + HALF;
  localparam int unsigned B_ALT    = B_CLOSE + HALF;
  localparam int unsigned B_HALVES = B_ALT + FLASH_STEPS;

  phase_e      phase;
  int unsigned idx_u;
  int unsigned base;
  int unsigned off;

  always_comb begin
    idx_u = 32'(idx_i);
    if (idx_u < B_RIGHT) begin
      phase = PH_LEFT;   base = 0;
    end else if (idx_u < B_OPEN) begin
      phase = PH_RIGHT;  base = B_RIGHT;
    end else if (idx_u < B_CLOSE) begin
      phase = PH_OPEN;   base = B_OPEN;
    end else if (idx_u < B_ALT) begin
      phase = PH_CLOSE;  base = B_CLOSE;
    end else if (idx_u < B_HALVES) begin
      phase = PH_ALT;    base = B_ALT;
    end else begin
      phase = PH_HALVES; base = B_HALVES;
    end
    off = idx_u - base;
  end

  for (genvar i = 0; i < LED_W; i++) begin : g_bit
    assign led_o[i] = led_bit_on(phase, off, i, LED_W);
  end
endmodule

// File: rtl/led_pattern_seq.sv
module led_pattern_seq
  import led_seq_pkg::*;
#(
  parameter int unsigned LED_W         = 8,
  parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_i,
  output logic [LED_W-1:0] led_o
);
  localparam int unsigned N_STEPS = 3 * LED_W + 2 * FLASH_STEPS;
  localparam int unsigned IDX_W   = $clog2(N_STEPS);

  logic             step_tick;
  logic [IDX_W-1:0] step_idx;

  led_step_timer #(.TICKS(TICKS_PER_SEC)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slow_i (slow_i),
    .tick_o (step_tick)
  );

  led_step_counter #(.N_STEPS(N_STEPS)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (step_tick),
    .idx_o  (step_idx)
  );

  led_pattern_map #(.LED_W(LED_W), .N_STEPS(N_STEPS)) i_map (
    .idx_i (step_idx),
    .led_o (led_o)
  );
endmodule

// File: rtl/led_seq_checker.sv
module led_seq_checker #(
  parameter int unsigned LED_W   = 8,
  parameter int unsigned N_STEPS = 32,
  parameter int unsigned TICKS   = 4,
  localparam int unsigned IDX_W  = $clog2(N_STEPS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [LED_W-1:0] led_i
);
  localparam int unsigned GAP_W = $clog2(2 * TICKS + 1);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= '0;
    else if (tick_i) gap_q <= '0;
    else             gap_q <= gap_q + 1'b1;
  end

  function automatic logic [LED_W-1:0] mirror(logic [LED_W-1:0] v);
    for (int i = 0; i < LED_W; i++) mirror[i] = v[LED_W-1-i];
  endfunction

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(led_i));

  assert_tick_interval_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (gap_q == GAP_W'(TICKS - 1) || gap_q == GAP_W'(2 * TICKS - 1)));

  assert_single_lit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(idx_i) < 2 * LED_W) |-> ($countones(led_i) == 1));

  assert_curtain_mirror_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(idx_i) >= 2 * LED_W && 32'(idx_i) < 3 * LED_W) |-> (led_i == mirror(led_i)));

  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && idx_i == IDX_W'(N_STEPS - 1)) |=> (idx_i == '0));

  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && idx_i != IDX_W'(N_STEPS - 1)) |=> (idx_i == $past(idx_i) + 1'b1));
endmodule

bind led_pattern_seq led_seq_checker #(
  .LED_W   (LED_W),
  .N_STEPS (N_STEPS),
  .TICKS   (TICKS_PER_SEC)
) i_led_seq_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (step_tick),
  .idx_i  (step_idx),
  .led_i  (led_o)
);

// File: tb/test_led_pattern_seq.sv
module test_led_pattern_seq;
  localparam int T = 4;

  typedef struct {
    logic [7:0] pat;
    int         dwell;
    logic       nspd;
    string      etag;
    string      htag;
  } item_t;

  logic       clk_i  = 1'b0;
  logic       rst_ni = 1'b0;
  logic       slow_i = 1'b0;
  logic [7:0] led_o;

  int    checks   = 0;
  int    failures = 0;
  bit    mon_done = 1'b0;
  item_t q[$];

  always #10 clk_i = ~clk_i;

  led_pattern_seq #(.LED_W(8), .TICKS_PER_SEC(T)) i_led_pattern_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slow_i (slow_i),
    .led_o  (led_o)
  );

  function automatic logic [7:0] exp_pat(int s);
    case (s)
      0: return 8'b00000001;  1: return 8'b00000010;
      2: return 8'b00000100;  3: return 8'b00001000;
      4: return 8'b00010000;  5: return 8'b00100000;
      6: return 8'b01000000;  7: return 8'b10000000;
      8: return 8'b10000000;  9: return 8'b01000000;
      10: return 8'b00100000; 11: return 8'b00010000;
      12: return 8'b00001000; 13: return 8'b00000100;
      14: return 8'b00000010; 15: return 8'b00000001;
      16: return 8'b00011000; 17: return 8'b00111100;
      18: return 8'b01111110; 19: return 8'b11111111;
      20: return 8'b01111110; 21: return 8'b00111100;
      22: return 8'b00011000; 23: return 8'b00000000;
      24: return 8'b10101010; 25: return 8'b01010101;
      26: return 8'b10101010; 27: return 8'b01010101;
      28: return 8'b11110000; 29: return 8'b00001111;
      30: return 8'b11110000; default: return 8'b00001111;
    endcase
  endfunction

  function automatic string tag_of(int s);
    if (s < 8)  return "R2";
    if (s < 16) return "R3";
    if (s < 20) return "R4";
    if (s < 24) return "R5";
    if (s < 28) return "R6";
    return "R7";
  endfunction

  task automatic chk(logic [7:0] got, logic [7:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s at %0t: led_o=%b expected=%b", tag, $time, got, exp);
    end
  endtask

  // driver: fills the scoreboard while reset is held, then releases it
  task automatic run_seq(int n, int mode);
    logic prev;
    rst_ni = 1'b0;
    #1;
    chk(led_o, 8'b00000001, "R1");
    prev = 1'b0;  // sampled speed after reset is 0 (R10)
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.pat   = exp_pat(k % 32);
      it.dwell = prev ? 2 * T : T;
      it.nspd  = (mode == 0) ? ((k % 7) < 3) : logic'(k % 2);
      it.etag  = (k == 0) ? "R1" : (k % 32 == 0) ? "R8" : tag_of(k % 32);
      it.htag  = (k == 0) ? "R1" : (k > 0 && q[k-1].dwell != it.dwell) ? "R10" : "R9";
      q.push_back(it);
      prev = it.nspd;
    end
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait (mon_done);
    mon_done = 1'b0;
  endtask

  // monitor: pops expected steps, checks entry and last cycle of each
  initial begin
    forever begin
      @(posedge rst_ni);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(led_o, it.pat, it.etag);
        slow_i = it.nspd;
        repeat (it.dwell - 1) begin @(negedge clk_i); #1; end
        chk(led_o, it.pat, it.htag);
        @(negedge clk_i); #1;
      end
      mon_done = 1'b1;
    end
  end

  initial begin
    slow_i = 1'b1;  // high during reset: first step must still be 1 s (R1, R10)
    run_seq(40, 0); // full pass plus wrap into the next (R8)
    repeat (3) @(negedge clk_i);  // reset lands mid-step
    slow_i = 1'b1;
    run_seq(12, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule